// File: doc/BRIEF.md
# Runtime-Formatted Serial Transmitter

This block turns bytes into asynchronous NRZ frames on one serial pin that rests at logic 1. Bytes come in through a valid/ready write port and wait in a 16-entry queue. A shift stage sends them one after another. Each frame is one low start bit, then the data bits with the least significant bit first. An optional parity bit and an optional multiprocessor marker bit can follow, and the frame ends with one or two high stop bits.

The data length, parity choice, stop count, marker enable and 16-bit bit-time divisor are plain control inputs. The block copies all of them when a frame begins. Changing them mid-frame therefore affects only later frames.

Back-pressure rules: a byte is taken on a rising clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` stays high while the queue holds fewer than 16 bytes. A write offered while `wr_ready` is low is dropped, and a producer must hold the byte until it sees ready. `wr_ready` also serves as the ready-for-more status flag, and `tx_empty` reports that nothing is queued and nothing is being shifted.

Top module: `fmt_uart_tx`

## Requirements
- R1: After reset `serial_out` is 1, `wr_ready` is 1 and `tx_empty` is 1, and the line stays at 1 whenever no frame is being sent.
- R2: A frame starts with one 0 bit, followed by `len_code`+1 data bits sent least significant bit first (`len_code` 0 gives 1 bit, 7 gives 8 bits).
- R3: `par_mode` 2'b01 appends an even-parity bit and 2'b10 appends an odd-parity bit, each computed over the data bits actually sent. Codes 2'b00 and 2'b11 send no parity bit.
- R4: `two_stop` = 1 ends the frame with two 1 bits, and 0 ends it with one.
- R5: Every bit lasts (`baud_div`+1)×8 clock cycles. The divisor and all format inputs are captured on the edge that starts the frame.
- R6: The queue holds 16 bytes. `wr_ready` is 1 exactly while fewer than 16 are held, and a write offered while `wr_ready` is 0 leaves no entry.
- R7: `tx_empty` is 1 exactly when the queue is empty and no frame is in progress.
- R8: While `tx_en` is 0 no new frame starts, but a frame already started runs to completion and writes are still accepted.
- R9: With `addr_mode` = 1 an extra bit equal to the `wr_addr` value written with that byte is sent after the data and any parity bit and before the stop bits.
- R10: `irq` is 1 exactly when `irq_en` is 1 and `wr_ready` is 1.
- R11: A frame starts on the edge after a byte is queued while the line is idle and `tx_en` is 1. If another byte is waiting, its start bit immediately follows the previous frame's last stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Allows new frames to start |
| irq_en | input | 1 | Enables the ready interrupt |
| baud_div | input | DIV_W | Bit-time divisor; bit = (value+1)×8 clocks |
| len_code | input | 3 | Data bits minus one |
| par_mode | input | 2 | 01 even, 10 odd, 00/11 none |
| two_stop | input | 1 | 1 selects two stop bits |
| addr_mode | input | 1 | Inserts the multiprocessor marker bit |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Queue can take a byte |
| wr_data | input | 8 | Byte to send |
| wr_addr | input | 1 | Marker value for this byte |
| serial_out | output | 1 | NRZ serial line, idles high |
| tx_empty | output | 1 | Queue empty and shifter idle |
| irq | output | 1 | Ready interrupt |

## Verification
The bench goes after the full-queue edge: a seventeenth write offered while `wr_ready` is low must vanish. A design that stored it, or dropped a real entry, shows a wrong frame during the drain. It disables transmission in the middle of a frame and changes the divisor during another. A design that truncated the frame or re-timed it from the live inputs drifts from the reference bit by bit. The bench also covers the shortest one-bit frame, both parity senses, the marker bit and back-to-back frames. A parity bit computed over unsent bits, a marker placed after the stop bits, or an idle gap between queued frames each shows up as a line mismatch on a specific cycle.

// File: rtl/fmt_uart_tx_pkg.sv
package fmt_uart_tx_pkg;
  localparam int DATA_W  = 8;
  localparam int LEN_W   = 3;
  // start + data + parity + marker + two stops
  localparam int FRAME_W = 1 + DATA_W + 1 + 1 + 2;
  localparam int NBITS_W = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    PAR_OFF  = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_OFF2 = 2'b11
  } par_e;
endpackage

// File: rtl/utx_fifo.sv
module utx_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             not_empty,
  output logic             not_full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    count;

  assign not_empty = (count != '0);
  assign not_full  = (count != CW'(DEPTH));
  assign head      = mem[rptr];

  always_ff @(posedge clk) begin
    if (push && not_full) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push && not_full) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop && not_empty) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({push && not_full, pop && not_empty})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/utx_framer.sv
module utx_framer
  import fmt_uart_tx_pkg::*;
(
  input  logic [DATA_W-1:0]  data,
  input  logic               addr_bit,
  input  logic [LEN_W-1:0]   len_code,
  input  logic [1:0]         par_mode,
  input  logic               two_stop,
  input  logic               addr_mode,
  output logic [FRAME_W-1:0] frame,
  output logic [NBITS_W-1:0] nbits
);
  logic [NBITS_W-1:0] pos;
  logic               ones;

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    pos      = NBITS_W'(1);
    ones     = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (LEN_W'(i) <= len_code) begin
        frame[pos] = data[i];
        ones       = ones ^ data[i];
        pos        = pos + 1'b1;
      end
    end
    if (par_mode == PAR_EVEN) begin
      frame[pos] = ones;
      pos        = pos + 1'b1;
    end else if (par_mode == PAR_ODD) begin
      frame[pos] = ~ones;
      pos        = pos + 1'b1;
    end
    if (addr_mode) begin
      frame[pos] = addr_bit;
      pos        = pos + 1'b1;
    end
    pos = pos + 1'b1;                 // first stop bit, already 1
    if (two_stop) pos = pos + 1'b1;   // second stop bit
    nbits = pos;
  end
endmodule

// File: rtl/utx_serializer.sv
module utx_serializer
  import fmt_uart_tx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               can_start,
  input  logic [FRAME_W-1:0] frame,
  input  logic [NBITS_W-1:0] nbits,
  input  logic [DIV_W-1:0]   baud_div,
  output logic               load,
  output logic               busy,
  output logic               line
);
  localparam int CNT_W = DIV_W + 3;

  logic [FRAME_W-1:0] shreg;
  logic [NBITS_W-1:0] left;
  logic [CNT_W-1:0]   cnt, lim;
  logic               bit_end, frame_end;

  assign bit_end   = busy && (cnt == lim);
  assign frame_end = bit_end && (left == NBITS_W'(1));
  assign load      = can_start && (!busy || frame_end);
  assign line      = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      shreg <= '1;
      left  <= '0;
      cnt   <= '0;
      lim   <= '0;
    end else if (load) begin
      busy  <= 1'b1;
      shreg <= frame;
      left  <= nbits;
      cnt   <= '0;
      lim   <= {baud_div, 3'b111};
    end else if (frame_end) begin
      busy  <= 1'b0;
      shreg <= '1;
      left  <= '0;
      cnt   <= '0;
    end else if (bit_end) begin
      shreg <= {1'b1, shreg[FRAME_W-1:1]};
      left  <= left - 1'b1;
      cnt   <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fmt_uart_tx.sv
module fmt_uart_tx
  import fmt_uart_tx_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             irq_en,
  input  logic [DIV_W-1:0] baud_div,
  input  logic [2:0]       len_code,
  input  logic [1:0]       par_mode,
  input  logic             two_stop,
  input  logic             addr_mode,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  input  logic             wr_addr,
  output logic             serial_out,
  output logic             tx_empty,
  output logic             irq
);
  localparam int EW = DATA_W + 1;

  logic [EW-1:0]      head;
  logic               q_nonempty, q_notfull, load, busy;
  logic [FRAME_W-1:0] frame;
  logic [NBITS_W-1:0] nbits;

  utx_fifo #(.WIDTH(EW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(wr_valid), .push_data({wr_addr, wr_data}),
    .pop(load), .head(head),
    .not_empty(q_nonempty), .not_full(q_notfull)
  );

  utx_framer u_framer (
    .data(head[DATA_W-1:0]), .addr_bit(head[DATA_W]),
    .len_code(len_code), .par_mode(par_mode),
    .two_stop(two_stop), .addr_mode(addr_mode),
    .frame(frame), .nbits(nbits)
  );

  utx_serializer #(.DIV_W(DIV_W)) u_ser (
    .clk(clk), .rst_n(rst_n),
    .can_start(q_nonempty && tx_en),
    .frame(frame), .nbits(nbits), .baud_div(baud_div),
    .load(load), .busy(busy), .line(serial_out)
  );

  assign wr_ready = q_notfull;
  assign tx_empty = !q_nonempty && !busy;
  assign irq      = irq_en && q_notfull;
endmodule

// File: rtl/fmt_uart_tx_chk.sv
module fmt_uart_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic irq_en,
  input logic wr_valid,
  input logic wr_ready,
  input logic serial_out,
  input logic tx_empty,
  input logic irq
);
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> serial_out);

  a_r7_empty_has_room: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> wr_ready);

  a_r6_full_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> !tx_empty);

  a_r8_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && !tx_en && !wr_valid) |=> tx_empty);

  a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  a_r10_irq_full: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> !irq);
endmodule

bind fmt_uart_tx fmt_uart_tx_chk u_chk (.*);

// File: tb/fmt_uart_tx_test.sv
module fmt_uart_tx_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 1'b0, irq_en = 1'b0, two_stop = 1'b0, addr_mode = 1'b0;
  logic [15:0] baud_div = '0;
  logic [2:0]  len_code = 3'd7;
  logic [1:0]  par_mode = 2'b00;
  logic wr_valid = 1'b0, wr_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic wr_ready, serial_out, tx_empty, irq;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  int  m_q[$];
  bit  m_bits[$];
  bit  m_busy = 0;
  int  m_cnt = 0, m_per = 8;

  always #(CLK_PERIOD/2) clk = ~clk;

  fmt_uart_tx uut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .irq_en(irq_en),
    .baud_div(baud_div), .len_code(len_code), .par_mode(par_mode),
    .two_stop(two_stop), .addr_mode(addr_mode),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .wr_addr(wr_addr), .serial_out(serial_out), .tx_empty(tx_empty), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic build(input int ent);
    int ones = 0;
    m_bits.delete();
    m_bits.push_back(1'b0);
    for (int i = 0; i <= int'(len_code); i++) begin
      m_bits.push_back(ent[i]);
      ones += ent[i];
    end
    if (par_mode == 2'b01) m_bits.push_back(ones % 2);
    if (par_mode == 2'b10) m_bits.push_back(1 - (ones % 2));
    if (addr_mode) m_bits.push_back(ent[8]);
    m_bits.push_back(1'b1);
    if (two_stop) m_bits.push_back(1'b1);
    m_per = (int'(baud_div) + 1) * 8;
    m_cnt = 0;
    m_busy = 1;
  endtask

  // applies the transition of the coming rising edge, using current inputs
  task automatic model_edge();
    bit acc = wr_valid && (m_q.size() < 16);
    bit was_busy = m_busy;
    bit ended = 0;
    if (m_busy) begin
      if (m_cnt == m_per - 1) begin
        m_cnt = 0;
        if (m_bits.size() == 1) begin
          m_bits.delete();
          m_busy = 0;
          ended = 1;
        end else void'(m_bits.pop_front());
      end else m_cnt++;
    end
    if ((!was_busy || ended) && m_q.size() > 0 && tx_en) build(m_q.pop_front());
    if (acc) m_q.push_back({wr_addr, wr_data});
  endtask

  task automatic compare();
    bit e_line  = m_busy ? m_bits[0] : 1'b1;
    bit e_ready = m_q.size() < 16;
    bit e_empty = (m_q.size() == 0) && !m_busy;
    bit e_irq   = irq_en && e_ready;
    chk(serial_out == e_line, "R2 R3 R4 R5 R8 R9 R11 serial_out", serial_out, e_line);
    chk(wr_ready == e_ready, "R6 wr_ready", wr_ready, e_ready);
    chk(tx_empty == e_empty, "R7 tx_empty", tx_empty, e_empty);
    chk(irq == e_irq, "R10 irq", irq, e_irq);
  endtask

  task automatic tick();
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic send(input logic [7:0] d, input logic a);
    wr_valid = 1'b1; wr_data = d; wr_addr = a;
    tick();
    wr_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 60000 && (m_busy || m_q.size() > 0); i++) tick();
    ticks(3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(serial_out == 1'b1, "R1 line after reset", serial_out, 1);
    chk(wr_ready == 1'b1, "R1 ready after reset", wr_ready, 1);
    chk(tx_empty == 1'b1, "R1 empty after reset", tx_empty, 1);
    compare();
    tx_en = 1'b1; irq_en = 1'b1;

    // R2 R11: 8 data bits, no parity, one stop, back-to-back pair
    send(8'hA5, 1'b0); send(8'h3C, 1'b0); drain();

    // R3 even parity, R4 two stops, 7 bits
    len_code = 3'd6; par_mode = 2'b01; two_stop = 1'b1;
    send(8'h55, 1'b0); send(8'h07, 1'b0); drain();

    // R3 odd parity, 5 bits, R5 slower divisor
    len_code = 3'd4; par_mode = 2'b10; two_stop = 1'b0; baud_div = 16'd2;
    send(8'hF3, 1'b0); drain();

    // R3 code 11 means no parity; R2 one-bit frame
    par_mode = 2'b11; len_code = 3'd0; baud_div = 16'd0;
    send(8'h01, 1'b0); send(8'h00, 1'b0); drain();

    // R9 marker bit, with parity and two stops around it
    len_code = 3'd7; par_mode = 2'b01; two_stop = 1'b1; addr_mode = 1'b1;
    send(8'h81, 1'b1); send(8'h81, 1'b0); drain();
    addr_mode = 1'b0; par_mode = 2'b00; two_stop = 1'b0;

    // R5 divisor changed mid-frame must not affect the running frame
    baud_div = 16'd3;
    send(8'h96, 1'b0); ticks(40); baud_div = 16'd0; drain();

    // R8 disable mid-frame: frame finishes, writes accepted, nothing new starts
    send(8'hC3, 1'b0); ticks(20); tx_en = 1'b0;
    send(8'h11, 1'b0); send(8'h22, 1'b0); ticks(200);
    chk(tx_empty == 1'b0, "R8 queued while disabled", tx_empty, 0);
    chk(serial_out == 1'b1, "R8 idle while disabled", serial_out, 1);
    tx_en = 1'b1; drain();

    // R6 fill 16, seventeenth write dropped, R10 irq follows ready
    tx_en = 1'b0;
    for (int i = 0; i < 17; i++) send(8'(i * 13 + 1), 1'b0);
    chk(wr_ready == 1'b0, "R6 full queue not ready", wr_ready, 0);
    chk(irq == 1'b0, "R10 irq low when full", irq, 0);
    ticks(5);
    tx_en = 1'b1; irq_en = 1'b0;
    ticks(30); irq_en = 1'b1;
    drain();
    chk(tx_empty == 1'b1, "R7 empty after drain", tx_empty, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule